// File: doc/BRIEF.md
# I2C Slave with Status Register

This block is a byte-oriented I2C target for a small host processor. It oversamples SCL and SDA on the system clock and finds START and STOP conditions. After every START it collects a 7-bit address, most significant bit first, followed by the read/write bit. It then compares the address with a host-programmed own address. On a hit it acknowledges. It then receives bytes and acknowledges each one, or it sends bytes that the host supplies until the master answers with a NACK.

The host reaches three registers through a simple read/write port: the data register, the own-address register and a status register. The status register carries byte-complete, address-hit, bus-busy, direction and received-acknowledge flags. A single interrupt line is raised both for an address hit and for each completed byte. The host tells the two apart by looking at the address-hit flag. SDA is open-drain: `sda_oe` high pulls the line low, and otherwise the line is released.

Top module: `i2c_slave_stat`

## Requirements
- R1: Status bit 5 (busy) goes to 1 when a START (SDA falling while SCL high) is seen and to 0 when a STOP (SDA rising while SCL high) is seen; the status register is at host address 2.
- R2: The first 8 bits after START are the address, MSB first, then the R/W bit. If the address equals the own address, status bit 6 is set, `irq` rises, and the block pulls SDA low during the 9th clock.
- R3: A non-matching address clears status bit 6 and gets no acknowledge. The rest of the transaction is ignored until the next START: no interrupt, no byte flag and SDA never driven.
- R4: Status bit 2 takes the R/W bit of a matching address: 1 means master reads (the block transmits), 0 means master writes (the block receives).
- R5: In receive mode each byte is acknowledged on the 9th clock. It is readable at host address 0, and status bit 7 and `irq` are set after its 8th bit.
- R6: In transmit mode the byte written to host address 0 is shifted out MSB first. SDA is released on the 9th clock. The level sampled there goes to status bit 0 (0 = ACK, 1 = NACK), and status bit 7 and `irq` are set.
- R7: After an ACK the next byte from host address 0 is sent. After a NACK, SDA stays released until the next START.
- R8: Status bits 4, 3 and 1 always read 0.
- R9: The own address is held in bits 6:0 of host address 1 and reads back. Any host access to address 0 clears status bits 7 and 6. A host write to address 2 clears `irq`. A read returns its data on `reg_rdata` one clock after `reg_rd`.
- R10: After reset the status reads 0x00, `irq` is 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 2 | Host register select: 0 data, 1 own address, 2 status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt: address hit or byte complete |

## Verification
A bus edge passes two synchronizer stages and one edge register before it is seen. Flags, `irq` and `sda_oe` then change on the next clock, so each result is due three to four system clocks after the SCL or SDA edge that causes it. The bench moves each line only after a quarter of an SCL period (16 clocks) has passed. It samples outputs and register reads only at the end of such a quarter, so every result has settled well before it is checked. Host reads are sampled on the falling clock edge that follows the one-cycle register latency. A per-clock monitor checks that `sda_oe` is never asserted in windows where the model forbids driving.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  // host register select
  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_OWN  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  // status bit positions
  localparam int unsigned SB_DONE  = 7;
  localparam int unsigned SB_MATCH = 6;
  localparam int unsigned SB_BUSY  = 5;
  localparam int unsigned SB_DIR   = 2;
  localparam int unsigned SB_RXAK  = 0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_p;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              busy,
  output logic              dir,
  output logic              rxak,
  output logic              addr_hit,
  output logic              addr_miss,
  output logic              byte_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; sh <= '0; rx_byte <= '0;
      sda_oe <= 1'b0; busy <= 1'b0; dir <= 1'b0; rxak <= 1'b0;
      addr_hit <= 1'b0; addr_miss <= 1'b0; byte_done <= 1'b0;
    end else begin
      addr_hit  <= 1'b0;
      addr_miss <= 1'b0;
      byte_done <= 1'b0;
      if (start_evt) begin
        ph <= PH_ADDR; cnt <= '0; busy <= 1'b1; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        ph <= PH_IDLE; busy <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (sh[BYTE_W-1:1] == own_addr) begin
                addr_hit <= 1'b1; dir <= sh[0]; sda_oe <= 1'b1; ph <= PH_AACK;
              end else begin
                addr_miss <= 1'b1; ph <= PH_SKIP;
              end
            end
          end
          PH_AACK: if (scl_fall) begin
            cnt <= '0;
            if (dir) begin
              sh <= tx_byte; sda_oe <= ~tx_byte[BYTE_W-1]; ph <= PH_TX;
            end else begin
              sda_oe <= 1'b0; ph <= PH_RX;
            end
          end
          PH_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              rx_byte <= sh; byte_done <= 1'b1; sda_oe <= 1'b1; ph <= PH_RACK;
            end
          end
          PH_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; ph <= PH_RX;
          end
          PH_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0; ph <= PH_TACK;
              end else begin
                sh <= {sh[BYTE_W-2:0], 1'b0}; sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          PH_TACK: begin
            if (scl_rise) begin
              rxak <= sda_s; byte_done <= 1'b1;
            end else if (scl_fall) begin
              if (!rxak) begin
                sh <= tx_byte; sda_oe <= ~tx_byte[BYTE_W-1]; cnt <= '0; ph <= PH_TX;
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_slave_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              addr_hit,
  input  logic              addr_miss,
  input  logic              byte_done,
  input  logic              busy,
  input  logic              dir,
  input  logic              rxak,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] own_addr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              st_match,
  output logic              st_done
);
  logic              data_acc;
  logic [BYTE_W-1:0] status;

  assign data_acc = (reg_wr | reg_rd) && reg_addr == RA_DATA;

  always_comb begin
    status           = '0;
    status[SB_DONE]  = st_done;
    status[SB_MATCH] = st_match;
    status[SB_BUSY]  = busy;
    status[SB_DIR]   = dir;
    status[SB_RXAK]  = rxak;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= RESET_ADDR; tx_byte <= '0; reg_rdata <= '0;
      irq <= 1'b0; st_match <= 1'b0; st_done <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_OWN)  own_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == RA_DATA) tx_byte  <= reg_wdata;

      if (addr_hit)                  st_match <= 1'b1;
      else if (addr_miss || data_acc) st_match <= 1'b0;

      if (byte_done)     st_done <= 1'b1;
      else if (data_acc) st_done <= 1'b0;

      if (addr_hit || byte_done)          irq <= 1'b1;
      else if (reg_wr && reg_addr == RA_STAT) irq <= 1'b0;

      if (reg_rd) begin
        case (reg_addr)
          RA_DATA: reg_rdata <= rx_byte;
          RA_OWN:  reg_rdata <= {1'b0, own_addr};
          RA_STAT: reg_rdata <= status;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_stat.sv
module i2c_slave_stat
  import i2c_slave_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, dir, rxak, addr_hit, addr_miss, byte_done, st_match, st_done;
  logic [ADDR_W-1:0] own_addr;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_bit_engine u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_oe(sda_oe), .rx_byte(rx_byte),
    .busy(busy), .dir(dir), .rxak(rxak), .addr_hit(addr_hit),
    .addr_miss(addr_miss), .byte_done(byte_done)
  );

  i2c_host_regs #(.RESET_ADDR(RESET_ADDR)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .addr_hit(addr_hit), .addr_miss(addr_miss),
    .byte_done(byte_done), .busy(busy), .dir(dir), .rxak(rxak), .rx_byte(rx_byte),
    .own_addr(own_addr), .tx_byte(tx_byte), .reg_rdata(reg_rdata), .irq(irq),
    .st_match(st_match), .st_done(st_done)
  );
endmodule

// File: rtl/i2c_slave_stat_chk.sv
module i2c_slave_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       irq,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       busy,
  input logic       match,
  input logic       done
);
  // R1
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> busy);
  // R1
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !busy);
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_oe);
  // R2
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (match || done));
  // R8
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd2) |=> (reg_rdata[4:3] == 2'b00 && !reg_rdata[1]));
endmodule

bind i2c_slave_stat i2c_slave_stat_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .irq(irq), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .start_evt(start_evt),
  .stop_evt(stop_evt), .busy(busy), .match(st_match), .done(st_done)
);

// File: tb/test_i2c_slave_stat.sv
`timescale 1ns/1ps
module test_i2c_slave_stat;
  localparam int Q = 16;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq;
  wire  bus = sda_m & ~sda_oe;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  int checks = 0, errors = 0;
  bit e_busy, e_match, e_dir, e_rxak, e_done, e_irq, oe_ok;

  i2c_slave_stat i_i2c_slave_stat (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] e_stat();
    return {e_done, e_match, e_busy, 2'b00, e_dir, 1'b0, e_rxak};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 2'd0) begin e_done = 0; e_match = 0; end
    if (a == 2'd2) e_irq = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    if (a == 2'd0) begin e_done = 0; e_match = 0; end
  endtask

  task automatic chk_stat(input string tag);
    logic [7:0] v;
    host_rd(2'd2, v);
    chk(tag, v, e_stat());
    chk({"R8 unused bits zero / ", tag}, v & 8'h1A, 0);
    chk({"irq / ", tag}, irq, e_irq);
  endtask

  task automatic bit_clk(input bit b, output bit seen, output bit oe_at);
    sda_m = b; idle(Q);
    scl = 1'b1; idle(Q);
    seen = bus; oe_at = sda_oe; idle(Q);
    scl = 1'b0; idle(Q);
  endtask

  task automatic wr_bits(input logic [7:0] v);
    bit s, o;
    for (int i = 7; i >= 0; i--) bit_clk(v[i], s, o);
  endtask

  task automatic rd_bits(output logic [7:0] v);
    bit s, o;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, s, o);
      v = {v[6:0], s};
    end
  endtask

  task automatic i2c_start();
    oe_ok = 0;
    sda_m = 1'b1; idle(Q);
    scl = 1'b1; idle(Q);
    sda_m = 1'b0; idle(Q);
    scl = 1'b0; idle(Q);
    e_busy = 1;
  endtask

  task automatic i2c_stop();
    oe_ok = 0;
    sda_m = 1'b0; idle(Q);
    scl = 1'b1; idle(Q);
    sda_m = 1'b1; idle(Q);
    e_busy = 0;
  endtask

  // per-clock model comparison: SDA may only be pulled while the model allows it
  always @(negedge clk) begin
    if (!rst && !oe_ok) begin
      checks++;
      if (sda_oe) begin
        errors++;
        $display("FAIL R3/R7 sda_oe actual 1 expected 0 at %0t", $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit s, o;
    idle(4); rst = 1'b0; idle(2);
    chk_stat("R10 reset status");
    chk("R10 reset sda_oe", sda_oe, 0);

    host_wr(2'd1, {1'b0, OWN});
    host_rd(2'd1, v);
    chk("R9 own address readback", v, {1'b0, OWN});

    // master write: two bytes
    i2c_start();
    chk_stat("R1 busy after START");
    oe_ok = 1;
    wr_bits({OWN, 1'b0});
    e_match = 1; e_dir = 0; e_irq = 1;
    chk_stat("R2 R4 address hit, write direction");
    bit_clk(1'b1, s, o);
    chk("R2 ACK on address", s, 0);
    host_wr(2'd2, 8'h00);
    chk("R9 irq cleared by status write", irq, 0);
    host_rd(2'd0, v);
    chk_stat("R9 data access clears match");

    wr_bits(8'hC3);
    e_done = 1; e_irq = 1;
    chk_stat("R5 byte 1 complete");
    bit_clk(1'b1, s, o);
    chk("R5 ACK byte 1", s, 0);
    host_rd(2'd0, v);
    chk("R5 received byte 1", v, 8'hC3);
    chk_stat("R9 done cleared by data read");
    host_wr(2'd2, 8'h00);

    wr_bits(8'h3C);
    e_done = 1; e_irq = 1;
    chk_stat("R5 byte 2 complete");
    bit_clk(1'b1, s, o);
    chk("R5 ACK byte 2", s, 0);
    host_rd(2'd0, v);
    chk("R5 received byte 2", v, 8'h3C);
    host_wr(2'd2, 8'h00);
    i2c_stop();
    chk_stat("R1 idle after STOP");

    // hit then repeated START with a foreign address
    i2c_start();
    oe_ok = 1;
    wr_bits({OWN, 1'b0});
    e_match = 1; e_irq = 1;
    bit_clk(1'b1, s, o);
    host_wr(2'd2, 8'h00);
    chk_stat("R2 match set before repeated START");
    i2c_start();
    wr_bits({7'h11, 1'b1});
    e_match = 0;
    chk_stat("R3 mismatch clears match, no irq");
    bit_clk(1'b1, s, o);
    chk("R3 no ACK on mismatch", s, 1);
    wr_bits(8'h00);
    bit_clk(1'b1, s, o);
    chk("R3 ignored byte not acknowledged", s, 1);
    chk_stat("R3 ignored byte leaves flags");
    i2c_stop();

    // master read: ACK then NACK
    host_wr(2'd0, 8'hA5);
    i2c_start();
    oe_ok = 1;
    wr_bits({OWN, 1'b1});
    e_match = 1; e_dir = 1; e_irq = 1;
    chk_stat("R4 read direction");
    bit_clk(1'b1, s, o);
    chk("R2 ACK on read address", s, 0);
    host_wr(2'd2, 8'h00);
    host_wr(2'd0, 8'h96);
    rd_bits(v);
    chk("R6 transmitted byte 1", v, 8'hA5);
    bit_clk(1'b0, s, o);
    chk("R6 SDA released on 9th clock", o, 0);
    e_rxak = 0; e_done = 1; e_irq = 1;
    chk_stat("R6 ACK sampled");
    host_wr(2'd2, 8'h00);
    rd_bits(v);
    chk("R7 next byte after ACK", v, 8'h96);
    bit_clk(1'b1, s, o);
    e_rxak = 1; e_done = 1; e_irq = 1;
    chk_stat("R6 NACK sampled");
    oe_ok = 0;
    host_wr(2'd2, 8'h00);
    rd_bits(v);
    chk("R7 released after NACK", v, 8'hFF);
    chk("R7 no irq after NACK", irq, 0);
    i2c_stop();
    chk_stat("R1 idle after read");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule